// File: doc/BRIEF.md
# Carry-Pipelined Ripple Adder

This block adds two unsigned or two's complement words of a configurable width at full clock rate while keeping the carry logic between registers only a few bit cells deep. The word is cut into groups of a configurable number of bits. A register holds each group's carry-out, so a carry moves forward by one group per clock. Each operand group is delayed by its group index before it reaches its adder cells. Each group's sum is then delayed by the number of groups still above it, so the whole result leaves on the same cycle.

A new operand pair may be presented on every clock. The aligned sum appears G clock edges later, where G is the number of groups, and the result wraps modulo 2 to the power of the width. A build-time switch removes the input skew and the output alignment. The adder can then sit in a chain of such stages that all work on already-skewed data. In that mode group i of each operand must belong to the word presented i cycles earlier, and group i of the sum leaves one cycle after its inputs.

Top module: `carry_pipe_adder`

## Requirements
- R1: A low level on rst_n at a rising clock edge clears every internal register, so sum_o reads 0 during reset and on the cycle after release.
- R2: With the skew enabled (SKEWED=0), sum_o equals (a_i + b_i) mod 2^WIDTH for the operands sampled G rising edges earlier, where G = ceil(WIDTH/GROUP).
- R3: A different operand pair is accepted on every clock with no stall, and back-to-back pairs that flip every carry give independent correct results.
- R4: The carry-in to the lowest group is 0 and the carry-out of the top group is discarded. For example, all-ones plus 1 gives 0, and 0x8000 plus 0x8000 gives 0 at a width of 16.
- R5: A carry produced in the lowest group reaches the top bit within the latency. For example, 0x7FFF plus 1 gives 0x8000, and 0x5555 plus 0xAAAB gives 0.
- R6: When GROUP does not divide WIDTH, the top group is narrower and the latency is still ceil(WIDTH/GROUP). For example, WIDTH=10 with GROUP=3 gives 4 groups and a latency of 4.
- R7: With GROUP equal to WIDTH there is a single group and the latency is one cycle.
- R8: With SKEWED=1, bits [i*GROUP +: GROUP] of a_i and b_i are taken as group i of the word presented i cycles earlier. Bits [i*GROUP +: GROUP] of sum_o then hold group i of that word's sum one rising edge after the group is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | WIDTH | First operand (aligned, or skewed when SKEWED=1) |
| b_i | input | WIDTH | Second operand (aligned, or skewed when SKEWED=1) |
| sum_o | output | WIDTH | Sum modulo 2^WIDTH (aligned, or skewed when SKEWED=1) |

## Verification
A wrong carry register or a mistimed skew stage does not corrupt the whole word at once. It shows at the ports as an error confined to the bits of one group and the groups above it, and only for words whose lower groups produce a carry. It appears G cycles after the offending pair goes in, or one cycle after it in skewed mode. Directed pairs that ripple a carry through every group, and pairs that alternate every cycle, make such a fault show on the first word affected. The bench therefore compares every output word on every cycle against a behavioural history of the inputs.

// File: rtl/carry_pipe_adder.sv
module carry_pipe_adder #(
  parameter int WIDTH  = 16,
  parameter int GROUP  = 2,
  parameter bit SKEWED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);

  localparam int NGRP  = (WIDTH + GROUP - 1) / GROUP;
  localparam int W0    = (GROUP < WIDTH) ? GROUP : WIDTH;

  logic [NGRP-1:0] cout;

  for (genvar i = 0; i < NGRP; i++) begin : g_grp
    localparam int LO   = i * GROUP;
    localparam int WG   = ((LO + GROUP) > WIDTH) ? (WIDTH - LO) : GROUP;
    localparam int IDLY = SKEWED ? 0 : i;
    localparam int ODLY = SKEWED ? 0 : (NGRP - 1 - i);

    logic [WG-1:0] ga, gb, s_q, s_out;
    logic          cin;
    logic [WG:0]   full;

    if (IDLY == 0) begin : g_nskew
      assign ga = a_i[LO +: WG];
      assign gb = b_i[LO +: WG];
    end else begin : g_skew
      logic [WG-1:0] ad [IDLY];
      logic [WG-1:0] bd [IDLY];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int j = 0; j < IDLY; j++) begin
            ad[j] <= '0;
            bd[j] <= '0;
          end
        end else begin
          ad[0] <= a_i[LO +: WG];
          bd[0] <= b_i[LO +: WG];
          for (int j = 1; j < IDLY; j++) begin
            ad[j] <= ad[j-1];
            bd[j] <= bd[j-1];
          end
        end
      end
      assign ga = ad[IDLY-1];
      assign gb = bd[IDLY-1];
    end

    if (i == 0) begin : g_cin0
      assign cin = 1'b0;
    end else begin : g_cinq
      logic c_q;
      always_ff @(posedge clk) begin
        if (!rst_n) c_q <= 1'b0;
        else        c_q <= cout[i-1];
      end
      assign cin = c_q;
    end

    assign full    = {1'b0, ga} + {1'b0, gb} + {{WG{1'b0}}, cin};
    assign cout[i] = full[WG];

    always_ff @(posedge clk) begin
      if (!rst_n) s_q <= '0;
      else        s_q <= full[WG-1:0];
    end

    if (ODLY == 0) begin : g_nalign
      assign s_out = s_q;
    end else begin : g_align
      logic [WG-1:0] sd [ODLY];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int j = 0; j < ODLY; j++) sd[j] <= '0;
        end else begin
          sd[0] <= s_q;
          for (int j = 1; j < ODLY; j++) sd[j] <= sd[j-1];
        end
      end
      assign s_out = sd[ODLY-1];
    end

    assign sum_o[LO +: WG] = s_out;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> sum_o == '0); // R1

  if (!SKEWED) begin : g_chk_aligned
    logic [WIDTH:0] ref_q [NGRP];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < NGRP; j++) ref_q[j] <= '0;
      end else begin
        ref_q[0] <= {1'b0, a_i} + {1'b0, b_i};
        for (int j = 1; j < NGRP; j++) ref_q[j] <= ref_q[j-1];
      end
    end
    AST_ALIGNED_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      sum_o == ref_q[NGRP-1][WIDTH-1:0]); // R2
    AST_CARRY_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      ref_q[NGRP-1][WIDTH] |-> ({1'b1, sum_o} == ref_q[NGRP-1])); // R4
  end else begin : g_chk_skewed
    AST_SKEW_GROUP0: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sum_o[W0-1:0] == $past(a_i[W0-1:0] + b_i[W0-1:0])); // R8
  end

endmodule

// File: tb/tb_carry_pipe_adder.sv
module tb_carry_pipe_adder;
  localparam real HALF = 2.5;
  localparam int  NCYC = 1200;
  localparam int  G16  = 8;
  localparam int  G10  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a16 = '0, b16 = '0, ska = '0, skb = '0;
  logic [15:0] s16, ssk;
  logic [9:0]  s10;
  logic [7:0]  s8;

  logic [15:0] wa [NCYC];
  logic [15:0] wb [NCYC];
  int checks = 0, fails = 0;

  always #(HALF) clk = ~clk;

  carry_pipe_adder #(.WIDTH(16), .GROUP(2), .SKEWED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .a_i(a16), .b_i(b16), .sum_o(s16));
  carry_pipe_adder #(.WIDTH(10), .GROUP(3), .SKEWED(1'b0)) dut_odd (
    .clk(clk), .rst_n(rst_n), .a_i(a16[9:0]), .b_i(b16[9:0]), .sum_o(s10));
  carry_pipe_adder #(.WIDTH(8), .GROUP(8), .SKEWED(1'b0)) dut_one (
    .clk(clk), .rst_n(rst_n), .a_i(a16[7:0]), .b_i(b16[7:0]), .sum_o(s8));
  carry_pipe_adder #(.WIDTH(16), .GROUP(2), .SKEWED(1'b1)) dut_skw (
    .clk(clk), .rst_n(rst_n), .a_i(ska), .b_i(skb), .sum_o(ssk));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sum_of(input int j);
    if (j < 0) return 16'h0;
    return wa[j] + wb[j];
  endfunction

  function automatic string tag_of(input int j);
    if (j >= 0 && j < 3) return "R4";
    if (j >= 3 && j < 6) return "R5";
    if (j >= 600 && j < 800) return "R3";
    return "R2";
  endfunction

  initial begin
    for (int k = 0; k < NCYC; k++) begin
      if (k >= 600 && k < 800) begin
        wa[k] = k[0] ? 16'hFFFF : 16'h5555;
        wb[k] = k[0] ? 16'h0001 : 16'hAAAA;
      end else begin
        wa[k] = 16'($urandom);
        wb[k] = 16'($urandom);
      end
    end
    wa[0] = 16'hFFFF; wb[0] = 16'h0001;
    wa[1] = 16'h8000; wb[1] = 16'h8000;
    wa[2] = 16'hFFFF; wb[2] = 16'hFFFF;
    wa[3] = 16'h7FFF; wb[3] = 16'h0001;
    wa[4] = 16'h5555; wb[4] = 16'hAAAB;
    wa[5] = 16'h01FF; wb[5] = 16'h0001;
    wa[6] = 16'h0000; wb[6] = 16'h0000;

    for (int r = 0; r < 4; r++) begin
      @(negedge clk);
      if (r > 0) begin
        check("R1 dut", 32'(s16), 32'h0);
        check("R1 dut_odd", 32'(s10), 32'h0);
        check("R1 dut_one", 32'(s8), 32'h0);
        check("R1 dut_skw", 32'(ssk), 32'h0);
      end
      a16 = 16'($urandom); b16 = 16'($urandom);
      ska = 16'($urandom); skb = 16'($urandom);
    end

    for (int k = 0; k < NCYC; k++) begin
      logic [15:0] e16, esk;
      logic [9:0]  e10;
      logic [7:0]  e8;
      @(negedge clk);
      if (k == 0) begin
        rst_n = 1'b1;
        check("R1 dut after release", 32'(s16), 32'h0);
      end
      e16 = sum_of(k - G16);
      check(tag_of(k - G16), 32'(s16), 32'(e16));
      e10 = (k - G10 < 0) ? 10'h0 : wa[k-G10][9:0] + wb[k-G10][9:0];
      check("R6", 32'(s10), 32'(e10));
      e8 = (k - 1 < 0) ? 8'h0 : wa[k-1][7:0] + wb[k-1][7:0];
      check("R7", 32'(s8), 32'(e8));
      for (int i = 0; i < 8; i++) begin
        logic [15:0] t;
        t = sum_of(k - 1 - i);
        esk[2*i +: 2] = t[2*i +: 2];
      end
      check("R8", 32'(ssk), 32'(esk));

      a16 = wa[k]; b16 = wb[k];
      for (int i = 0; i < 8; i++) begin
        ska[2*i +: 2] = (k - i >= 0) ? wa[k-i][2*i +: 2] : 2'b00;
        skb[2*i +: 2] = (k - i >= 0) ? wb[k-i][2*i +: 2] : 2'b00;
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(2.0 * HALF * 200000.0);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule